// File: doc/BRIEF.md
# Key-Armed Prescaled Watchdog Timer

This block is a watchdog timer that software must keep servicing. After reset it sits idle and can never request a reset. It wakes the first time software writes the 16-bit service key 0x4EA9 to the kick register. From then on, every further write of that key restarts the countdown from a programmable reload value. A prescaler divides the clock so the countdown moves only once every 2^PRE_W cycles. With the default PRE_W of 16, that is once every 65536 cycles.

If software stops writing the key, the count runs down. When it reaches zero, the block raises its reset-request output for exactly one clock and drops back to the idle state. Software cannot stop a running watchdog. Only a timeout or a reset makes it idle again. The write port has a one-bit selector: 0 addresses the reload register and 1 addresses the kick register. The current count can be read at all times.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the watchdog is idle, `rst_req_o` is low, `count_o` is 0 and the reload value is RELOAD_RST. While idle, `rst_req_o` never rises, whatever time passes.
- R2: A write with `wr_sel`=0 stores `wr_data[CNT_W-1:0]` as the reload value. It does not change `count_o`, and the new value is used from the next valid kick.
- R3: A write with `wr_sel`=1 and `wr_data`=0x4EA9 arms an idle watchdog.
- R4: Each write of 0x4EA9 with `wr_sel`=1 loads `count_o` with the reload value, visible one cycle after the write. It also clears the prescaler, so the first decrement follows 2^PRE_W cycles later.
- R5: While armed, `count_o` falls by one exactly every 2^PRE_W clock cycles.
- R6: When an armed count reaches 0, `rst_req_o` is high for exactly one cycle. In that same cycle `count_o` reads 0 and the watchdog becomes idle. The count then holds at 0.
- R7: A write with `wr_sel`=1 of any value other than 0x4EA9 is ignored. It does not arm the block, reload the count or disturb the running timeline.
- R8: Once armed, software cannot disarm the watchdog, and reload-register writes do not stop it. Only a timeout or a reset makes it idle.
- R9: A reload value of 0 behaves as one period: the request comes 2^PRE_W cycles after the kick.
- R10: A valid kick that lands in the same cycle as a prescaler tick wins. The count is reloaded rather than decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | Register select: 0 reload, 1 kick |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current countdown value |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with PRE_W=2, so each period is four cycles and a whole countdown takes tens of cycles rather than millions. It also uses CNT_W=8 and a reload reset value of 6. With these settings the bench sweeps every reload value from 0 to 9 and checks the count and the request output on each cycle of each timeline. The short period also puts the rarer situations in reach, each at an exact cycle: a kick landing on a tick, a wrong key in mid-countdown, a reload write while armed, and a reset while armed.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // Register selector on the write port
   typedef enum logic {
      WDG_SEL_RELOAD = 1'b0,
      WDG_SEL_KICK   = 1'b1
   } wdg_sel_e;

   localparam int unsigned WDG_MAX_PRE_W = 32;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int unsigned PRE_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (PRE_W == 0) begin : g_direct
         // No division: every armed cycle is a tick
         assign tick = run;
      end else begin : g_div
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (clr)    pre_q <= '0;
            else if (run)    pre_q <= pre_q + 1'b1;
         end
         assign tick = run && (pre_q == {PRE_W{1'b1}});
      end
   endgenerate
endmodule

// File: rtl/wdg_key_detect.sv
module wdg_key_detect
   import wdg_pkg::*;
#(
   parameter int unsigned      DATA_W = 16,
   parameter logic [DATA_W-1:0] KEY   = 16'h4EA9
) (
   input  logic              wr_en,
   input  wdg_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              kick_ok,
   output logic              reload_we
);
   always_comb begin
      kick_ok   = wr_en && (wr_sel == WDG_SEL_KICK) && (wr_data == KEY);
      reload_we = wr_en && (wr_sel == WDG_SEL_RELOAD);
   end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned      CNT_W      = 16,
   parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             kick,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] rld,
   output logic             armed,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rld <= RELOAD_RST;
      else if (reload_we) rld <= reload_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         armed  <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (kick) begin
            armed <= 1'b1;
            count <= rld;
         end else if (armed && tick) begin
            if (count <= ONE) begin
               count  <= '0;
               armed  <= 1'b0;
               expire <= 1'b1;
            end else begin
               count <= count - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
   import wdg_pkg::*;
#(
   parameter int unsigned       DATA_W     = 16,
   parameter int unsigned       CNT_W      = 16,
   parameter int unsigned       PRE_W      = 16,
   parameter logic [DATA_W-1:0] KEY        = 16'h4EA9,
   parameter logic [CNT_W-1:0]  RELOAD_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic              rst_req_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdg_keyed: CNT_W must lie in 1..DATA_W");
      end
      if (PRE_W > WDG_MAX_PRE_W) begin : g_bad_pre
         $error("wdg_keyed: PRE_W too large");
      end
   endgenerate

   logic             kick_ok;
   logic             reload_we;
   logic             tick;
   logic             armed;
   logic [CNT_W-1:0] rld;
   logic [CNT_W-1:0] reload_val;

   assign reload_val = wr_data[CNT_W-1:0];

   wdg_key_detect #(.DATA_W(DATA_W), .KEY(KEY)) u_key (
      .wr_en    (wr_en),
      .wr_sel   (wdg_sel_e'(wr_sel)),
      .wr_data  (wr_data),
      .kick_ok  (kick_ok),
      .reload_we(reload_we)
   );

   wdg_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (armed),
      .clr  (kick_ok),
      .tick (tick)
   );

   wdg_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload_we (reload_we),
      .reload_val(reload_val),
      .kick      (kick_ok),
      .tick      (tick),
      .count     (count_o),
      .rld       (rld),
      .armed     (armed),
      .expire    (rst_req_o)
   );
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             armed,
   input logic             kick,
   input logic             tick,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] rld,
   input logic             rst_req
);
   assert_req_needs_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(armed));

   assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (armed && count == $past(rld)));

   assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !kick) |=> (count == $past(count) || count == CNT_W'($past(count) - CNT_W'(1))));

   assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!armed && count == '0));

   assert_stay_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !kick && !(tick && count <= CNT_W'(1))) |=> armed);
endmodule

bind wdg_keyed wdg_keyed_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .armed  (armed),
   .kick   (kick_ok),
   .tick   (tick),
   .count  (count_o),
   .rld    (rld),
   .rst_req(rst_req_o)
);

// File: tb/wdg_keyed_test.sv
module wdg_keyed_test;
   localparam int CLK_PERIOD = 10;
   localparam int PRE_W      = 2;
   localparam int P          = 1 << PRE_W;
   localparam int CNT_W      = 8;
   localparam int RST_RLD    = 6;
   localparam logic [15:0] KEY = 16'h4EA9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              wr_sel = 1'b0;
   logic [15:0]       wr_data = '0;
   logic [CNT_W-1:0]  count_o;
   logic              rst_req_o;
   int                n_chk = 0;
   int                n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdg_keyed #(.DATA_W(16), .CNT_W(CNT_W), .PRE_W(PRE_W), .KEY(KEY),
               .RELOAD_RST(CNT_W'(RST_RLD))) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .count_o(count_o), .rst_req_o(rst_req_o));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input bit en, input bit sel, input logic [15:0] d);
      wr_en = en; wr_sel = sel; wr_data = d;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_reload(input int v);
      drive(1'b1, 1'b0, 16'(v));
      step();
      drive(1'b0, 1'b0, 16'h0);
   endtask

   task automatic kick_now(input int exp_n, input string tag);
      drive(1'b1, 1'b1, KEY);
      step();
      drive(1'b0, 1'b0, 16'h0);
      check(int'(count_o) == exp_n, tag, int'(count_o), exp_n);
      check(rst_req_o == 1'b0, "R4 no request on kick", int'(rst_req_o), 0);
   endtask

   // Cycle-exact timeline after a valid kick; optional wrong-key or reload write
   task automatic timeline(input int n, input int bad_at, input int cfg_at, input int cfg_val);
      int eff;
      int exp_cnt;
      eff = (n == 0) ? 1 : n;
      for (int i = 1; i <= eff * P; i++) begin
         if (i == bad_at)      drive(1'b1, 1'b1, 16'h4EA8);
         else if (i == cfg_at) drive(1'b1, 1'b0, 16'(cfg_val));
         else                  drive(1'b0, 1'b0, 16'h0);
         step();
         exp_cnt = (n == 0) ? 0 : n - i / P;
         check(int'(count_o) == exp_cnt, "R5 count per period", int'(count_o), exp_cnt);
         check(rst_req_o == (i == eff * P), (n == 0) ? "R9 zero reload" : "R6 request timing",
               int'(rst_req_o), int'(i == eff * P));
      end
      drive(1'b0, 1'b0, 16'h0);
      step();
      check(rst_req_o == 1'b0, "R6 one-cycle pulse", int'(rst_req_o), 0);
      check(count_o == '0, "R6 holds zero", int'(count_o), 0);
   endtask

   task automatic idle_quiet(input int cycles, input string tag);
      int c0;
      c0 = int'(count_o);
      for (int i = 0; i < cycles; i++) begin
         step();
         check(rst_req_o == 1'b0, tag, int'(rst_req_o), 0);
         check(int'(count_o) == c0, tag, int'(count_o), c0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      drive(1'b0, 1'b0, 16'h0);
      repeat (3) step();
      check(rst_req_o == 1'b0, "R1 reset request low", int'(rst_req_o), 0);
      check(count_o == '0, "R1 reset count", int'(count_o), 0);
      rst_n = 1'b1;
      idle_quiet(3 * P, "R1 idle never requests");

      // Wrong key from idle does not arm
      drive(1'b1, 1'b1, 16'h4EA8);
      step();
      drive(1'b0, 1'b0, 16'h0);
      idle_quiet(3 * P, "R7 wrong key ignored when idle");

      // First arming uses the reset reload value
      kick_now(RST_RLD, "R3 arm with reset reload R1");
      timeline(RST_RLD, -1, -1, 0);
      idle_quiet(2 * P, "R6 idle after timeout");

      // Sweep of reload values
      for (int n = 0; n <= 9; n++) begin
         set_reload(n);
         check(count_o == '0, "R2 reload write keeps count", int'(count_o), 0);
         kick_now(n, "R4 reload on key");
         timeline(n, -1, -1, 0);
      end

      // Wrong key mid-run
      set_reload(5);
      kick_now(5, "R4 reload on key");
      timeline(5, P + 1, -1, 0);

      // Reload write while armed: no disarm, no count change, used on next kick
      set_reload(4);
      kick_now(4, "R4 reload on key");
      timeline(4, -1, 2, 9);
      kick_now(9, "R2 new reload applies on next kick");
      timeline(9, -1, -1, 0);

      // Repeated kicks, second one on a tick edge
      set_reload(3);
      kick_now(3, "R4 reload on key");
      for (int i = 1; i < 2 * P; i++) begin
         step();
         check(int'(count_o) == 3 - i / P, "R5 count before rekick", int'(count_o), 3 - i / P);
      end
      kick_now(3, "R10 kick beats tick");
      timeline(3, -1, -1, 0);

      // Reset while armed
      set_reload(2);
      kick_now(2, "R4 reload on key");
      step();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      check(count_o == '0, "R8 reset disarms", int'(count_o), 0);
      idle_quiet(3 * P, "R8 idle after reset");
      kick_now(RST_RLD, "R1 reload value back to reset");
      timeline(RST_RLD, -1, -1, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule